// File: doc/BRIEF.md
# Shared-Comparator Relational Selector

This block reduces two unsigned operands to a single truth bit chosen by a 3-bit function code. The code can select either of two constants or one of six relational tests: equal, not equal, greater-or-equal, less-or-equal, less-than and greater-than. The tests compare the operands as unsigned binary numbers.

Only two magnitude circuits exist: one equality detector and one greater-than detector. Every code reuses them, and each relation is formed from their two outputs with a gate or two. This keeps the comparator area fixed no matter how many codes the block offers.

A parameter selects how the bit leaves the block. It can be a plain combinational output, or it can be captured in a flop that loads only while the enable is high.

Top module: `relsel_unit`

## Requirements
- R1: Function code 3'b000 yields 0 and code 3'b001 yields 1, whatever the operands.
- R2: Code 3'b010 yields 1 exactly when the operands are equal, and code 3'b011 yields 1 exactly when they differ.
- R3: Code 3'b100 yields 1 when operand A is greater than or equal to operand B (unsigned).
- R4: Code 3'b101 yields 1 when A is less than or equal to B (unsigned).
- R5: Code 3'b110 yields 1 when A is strictly less than B, so equal operands give 0.
- R6: Code 3'b111 yields 1 when A is strictly greater than B (unsigned).
- R7: The shared equality result and greater-than result are never both 1 for the same operand pair.
- R8: With the registered output (REGISTERED=1), the result takes the newly selected value at a rising clock edge where the enable is high, and holds its value at an edge where the enable is low.
- R9: With the registered output, an active-low reset clears the result to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| en | input | 1 | Load enable for the output register |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| func | input | 3 | Function code |
| result | output | 1 | Selected truth bit |

## Verification
The assertions are clocked, so they assume that the operands and the function code are stable and known at each rising edge. They also assume that the enable is never X once reset has been released. The bench meets these assumptions by changing its inputs only on falling edges and by driving every input from reset onwards. Its stimulus sweeps all eight codes over operand pairs that are zero, all-ones, equal, and off by one in each direction, and it also uses random pairs. It lowers the enable for stretches while the inputs change underneath, so that holding the result is exercised.

// File: rtl/relsel_unit.sv
module relsel_unit #(
  parameter int WIDTH      = 16,
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       func,
  output logic             result
);

  logic is_eq, is_gt, rel_bit;

  assign is_eq = (op_a == op_b);
  assign is_gt = (op_a > op_b);

  always_comb begin
    unique case (func)
      3'b000:  rel_bit = 1'b0;
      3'b001:  rel_bit = 1'b1;
      3'b010:  rel_bit = is_eq;
      3'b011:  rel_bit = ~is_eq;
      3'b100:  rel_bit = is_eq | is_gt;
      3'b101:  rel_bit = ~is_gt;
      3'b110:  rel_bit = ~is_gt & ~is_eq;
      default: rel_bit = is_gt;
    endcase
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  result <= 1'b0;
        else if (en) result <= rel_bit;
      end

      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(result));
      assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (result == $past(rel_bit)));
    end else begin : g_comb
      assign result = rel_bit;
    end
  endgenerate

  assert_const_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (func[2:1] == 2'b00) |-> (rel_bit == func[0]));
  assert_ne_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (func == 3'b011) |-> (rel_bit == (op_a != op_b)));
  assert_ge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (func == 3'b100) |-> (rel_bit == (op_a >= op_b)));
  assert_le_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (func == 3'b101) |-> (rel_bit == (op_a <= op_b)));
  assert_lt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (func == 3'b110) |-> (rel_bit == (op_a < op_b)));
  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_eq && is_gt));

endmodule

// File: tb/relsel_unit_tb.sv
module relsel_unit_tb;
  localparam int WIDTH = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [WIDTH-1:0] op_a = '0, op_b = '0;
  logic [2:0] func = 3'b000;
  logic result;

  int n_tests = 0;
  int n_fail = 0;
  bit exp_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  relsel_unit #(.WIDTH(WIDTH), .REGISTERED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .op_a(op_a), .op_b(op_b),
    .func(func), .result(result));

  function automatic bit ref_rel(input logic [2:0] f, input int unsigned a, input int unsigned b);
    case (f)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return a == b;
      3'd3: return a != b;
      3'd4: return a >= b;
      3'd5: return a <= b;
      3'd6: return a < b;
      default: return a > b;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'd0, 3'd1: return "R1";
      3'd2, 3'd3: return "R2";
      3'd4: return "R3";
      3'd5: return "R4";
      3'd6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input bit exp);
    n_tests++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s: func=%b a=%h b=%h en=%b got %b expected %b",
               tag, func, op_a, op_b, en, result, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    if (!rst_n) exp_q = 1'b0;
    else if (en) exp_q = ref_rel(func, op_a, op_b);
    @(negedge clk);
    check(tag, exp_q);
  endtask

  task automatic apply(input logic [2:0] f, input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    func = f; op_a = a; op_b = b; en = 1'b1;
    step(tag_of(f));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] pa [8];
    logic [WIDTH-1:0] pb [8];
    bit r_eq, r_gt;
    pa[0] = '0;   pb[0] = '0;
    pa[1] = '1;   pb[1] = '1;
    pa[2] = '0;   pb[2] = '1;
    pa[3] = '1;   pb[3] = '0;
    pa[4] = 16'd100; pb[4] = 16'd101;
    pa[5] = 16'd101; pb[5] = 16'd100;
    pa[6] = 16'h8000; pb[6] = 16'h7fff;
    pa[7] = 16'h1234; pb[7] = 16'h1234;

    @(negedge clk);
    func = 3'b001; en = 1'b1;
    step("R9");
    step("R9");
    @(negedge clk);
    rst_n = 1'b1;

    for (int f = 0; f < 8; f++)
      for (int p = 0; p < 8; p++)
        apply(3'(f), pa[p], pb[p]);

    for (int i = 0; i < 400; i++) begin
      logic [WIDTH-1:0] ra = WIDTH'($urandom);
      logic [WIDTH-1:0] rb = (i % 5 == 0) ? ra : WIDTH'($urandom);
      apply(3'($urandom_range(7)), ra, rb);
    end

    for (int p = 0; p < 8; p++) begin
      apply(3'b010, pa[p], pb[p]);
      r_eq = result;
      apply(3'b111, pa[p], pb[p]);
      r_gt = result;
      n_tests++;
      if (r_eq && r_gt) begin
        n_fail++;
        $display("FAIL R7: a=%h b=%h eq=%b gt=%b expected not both 1", pa[p], pb[p], r_eq, r_gt);
      end
    end

    apply(3'b001, '0, '0);
    en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      func = 3'($urandom_range(7));
      op_a = WIDTH'($urandom);
      op_b = WIDTH'($urandom);
      if (i == 0) func = 3'b000;
      step("R8");
    end
    en = 1'b1; func = 3'b000;
    step("R8");
    en = 1'b0; func = 3'b001;
    step("R8");
    step("R8");

    rst_n = 1'b0;
    #1;
    check("R9", 1'b0);
    step("R9");
    @(negedge clk);
    rst_n = 1'b1;
    apply(3'b110, 16'd5, 16'd5);
    apply(3'b110, 16'd4, 16'd5);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule